// File: doc/BRIEF.md
# Iterative Sponge Permutation Engine

This block applies a fixed 48-step keyed-by-index permutation to a 128-bit sponge state. The state is viewed as four 32-bit words W0..W3, with W0 in bits [31:0] and W3 in bits [127:96]. A caller presents a state and pulses a start input. The engine then iterates a step datapath once per clock and raises a one-cycle completion pulse. The permuted state stays on the output until the next accepted start.

Each step mixes the step index into the state. It passes one word through a nonlinear mixing function. That function substitutes every nibble through a 16-entry table and then combines the eight substituted nibbles with XOR-only diffusion. A parameter chains several step datapaths within one clock, which trades logic depth for fewer cycles. Padding, absorbing and squeezing are left to the surrounding logic.

Top module: `sponge_perm_engine`

## Requirements
- R1: While reset is held and after its release, busy_o and done_o are 0 and state_o is all zeros until a start is accepted.
- R2: A start_i high while busy_o is 0 is accepted on that clock edge. It loads state_i, sets the step index to 0 and raises busy_o from the next cycle.
- R3: done_o is high for exactly one cycle, 48/UNFOLD clock edges after the accepting edge. busy_o falls on the same edge, and done_o is never high together with busy_o.
- R4: Step r, with r from 0 to 47 and taken as a zero-extended 32-bit value, replaces the old words with these values: W0' = W3^r; W1' = G(W3^r^W2)^W0^W1; W2' = W1; W3' = ROT_r(W1)^W0^W2.
- R5: ROT_r is a left circular rotation. It rotates by 19 bits when r mod 3 is 0, by 1 bit when r mod 3 is 1, and by 14 bits when r mod 3 is 2.
- R6: G splits its word into nibbles n0..n7, with n_i at bits [4i+3:4i]. It substitutes each nibble through the table F,8,9,7,6,3,0,C,1,2,4,B,D,E,A,5, indexed by nibble values 0..F.
- R7: Output nibble j of G is the XOR of the substituted nibbles chosen by mask j. Bit 7-i of a mask selects nibble i. The masks for j = 0..7 are 01111001, 10111100, 11010110, 11100011, 01111110, 10110111, 11011011, 11101101.
- R8: A start_i high while busy_o is 1 has no effect on the running permutation, its result or its timing.
- R9: While idle, state_o holds the last result until the next accepted start.
- R10: Any UNFOLD that divides 48 yields the same result as UNFOLD = 1, in 48/UNFOLD cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to permute state_i |
| state_i | input | 128 | State to permute, W0 in the low word |
| busy_o | output | 1 | Permutation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| state_o | output | 128 | Current or final state |

## Verification
busy_o is due one edge after the accepting start. done_o and the final state_o are due exactly 48/UNFOLD edges after that start, so 48 edges for the rolled instance and 12 for the four-way unrolled one. The bench counts edges from the accepting start and samples both instances at each falling edge. At each count it compares busy_o and done_o with the values due, and it compares state_o against a behavioural permutation model in the cycle that done_o is due. One edge later it checks that done_o has dropped and state_o is held. A start pulse in the middle of a run must change neither that schedule nor the result.

// File: rtl/sperm_pkg.sv
package sperm_pkg;

  localparam int WORD_W      = 32;
  localparam int NIB_PER_W   = WORD_W / 4;
  localparam int STATE_W     = 4 * WORD_W;
  localparam int TOTAL_STEPS = 48;
  localparam int IDX_W       = $clog2(TOTAL_STEPS + 1);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t w3;
    word_t w2;
    word_t w1;
    word_t w0;
  } state_t;

  // diffusion masks, mask j at bits [8j+7:8j]; bit 7-i selects nibble i
  localparam logic [63:0] DIFF_MASKS = {
    8'b11101101, 8'b11011011, 8'b10110111, 8'b01111110,
    8'b11100011, 8'b11010110, 8'b10111100, 8'b01111001
  };

  localparam int ROT_A = 19;
  localparam int ROT_B = 1;
  localparam int ROT_C = 14;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

endpackage

// File: rtl/sperm_gfunc.sv
module sperm_gfunc
  import sperm_pkg::*;
#(
  parameter logic [63:0] SBOX = 64'h5AEDB421C036798F
) (
  input  word_t x_i,
  output word_t y_o
);

  logic [3:0] sub_nib [NIB_PER_W];

  for (genvar i = 0; i < NIB_PER_W; i++) begin : g_sub
    assign sub_nib[i] = SBOX[4*x_i[4*i +: 4] +: 4];
  end

  always_comb begin
    y_o = '0;
    for (int j = 0; j < NIB_PER_W; j++) begin
      for (int i = 0; i < NIB_PER_W; i++) begin
        if (DIFF_MASKS[8*j + 7 - i]) begin
          y_o[4*j +: 4] = y_o[4*j +: 4] ^ sub_nib[i];
        end
      end
    end
  end

endmodule

// File: rtl/sperm_step.sv
module sperm_step
  import sperm_pkg::*;
#(
  parameter logic [63:0] SBOX = 64'h5AEDB421C036798F
) (
  input  state_t           s_i,
  input  logic [IDX_W-1:0] idx_i,
  output state_t           s_o
);

  word_t idx_w;
  word_t keyed;
  word_t g_out;
  word_t rot_w;
  logic [1:0] phase;

  assign idx_w = {{(WORD_W-IDX_W){1'b0}}, idx_i};
  assign keyed = s_i.w3 ^ idx_w;
  assign phase = 2'(idx_i % 3);

  sperm_gfunc #(.SBOX(SBOX)) u_g (
    .x_i (keyed ^ s_i.w2),
    .y_o (g_out)
  );

  always_comb begin
    unique case (phase)
      2'd0:    rot_w = rotl(s_i.w1, ROT_A);
      2'd1:    rot_w = rotl(s_i.w1, ROT_B);
      default: rot_w = rotl(s_i.w1, ROT_C);
    endcase
  end

  assign s_o.w0 = keyed;
  assign s_o.w1 = g_out ^ s_i.w0 ^ s_i.w1;
  assign s_o.w2 = s_i.w1;
  assign s_o.w3 = rot_w ^ s_i.w0 ^ s_i.w2;

endmodule

// File: rtl/sperm_ctrl.sv
module sperm_ctrl
  import sperm_pkg::*;
#(
  parameter int UNFOLD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             load_o,
  output logic             adv_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] STRIDE   = IDX_W'(UNFOLD);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_STEPS - UNFOLD);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last;

  assign load_o = start_i & ~busy_q;
  assign adv_o  = busy_q;
  assign last   = busy_q && (idx_q == LAST_IDX);

  always_comb begin
    idx_d  = idx_q;
    busy_d = busy_q;
    done_d = last;
    if (load_o) begin
      idx_d  = '0;
      busy_d = 1'b1;
    end else if (adv_o) begin
      idx_d = idx_q + STRIDE;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

endmodule

// File: rtl/sponge_perm_engine.sv
module sponge_perm_engine
  import sperm_pkg::*;
#(
  parameter int          UNFOLD = 1,
  parameter logic [63:0] SBOX   = 64'h5AEDB421C036798F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [STATE_W-1:0] state_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [STATE_W-1:0] state_o
);

  if ((UNFOLD < 1) || (TOTAL_STEPS % UNFOLD != 0)) begin : g_bad_unfold
    $error("UNFOLD must divide the step count");
  end

  logic             load;
  logic             adv;
  logic [IDX_W-1:0] idx;
  state_t           state_q, state_d;
  state_t           chain [UNFOLD+1];

  sperm_ctrl #(.UNFOLD(UNFOLD)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .adv_o   (adv),
    .idx_o   (idx),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  assign chain[0] = state_q;

  for (genvar k = 0; k < UNFOLD; k++) begin : g_unfold
    sperm_step #(.SBOX(SBOX)) u_step (
      .s_i   (chain[k]),
      .idx_i (idx + IDX_W'(k)),
      .s_o   (chain[k+1])
    );
  end

  always_comb begin
    state_d = state_q;
    if (load)     state_d = state_t'(state_i);
    else if (adv) state_d = chain[UNFOLD];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/sperm_checker.sv
module sperm_checker
  import sperm_pkg::*;
#(
  parameter int UNFOLD = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [STATE_W-1:0] state_o
);

  localparam int RUN_CYCLES = TOTAL_STEPS / UNFOLD;

  logic [IDX_W:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_len <= '0;
    else if (start_i && !busy_o)  run_len <= '0;
    else if (busy_o)              run_len <= run_len + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (!busy_o && !done_o));

  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_run_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_len == (IDX_W+1)'(RUN_CYCLES)));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(state_o));

endmodule

bind sponge_perm_engine sperm_checker #(.UNFOLD(UNFOLD)) u_sperm_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .state_o (state_o)
);

// File: tb/sponge_perm_engine_bench.sv
`timescale 1ns/1ps
module sponge_perm_engine_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] state_i = '0;
  logic         busy1, done1, busy4, done4;
  logic [127:0] out1, out4;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sponge_perm_engine #(.UNFOLD(1)) u_sponge_perm_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .state_i(state_i),
    .busy_o(busy1), .done_o(done1), .state_o(out1)
  );

  sponge_perm_engine #(.UNFOLD(4)) u_sponge_perm_engine_x4 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .state_i(state_i),
    .busy_o(busy4), .done_o(done4), .state_o(out4)
  );

  logic [3:0] sub_tbl [16] = '{4'hF, 4'h8, 4'h9, 4'h7, 4'h6, 4'h3, 4'h0, 4'hC,
                               4'h1, 4'h2, 4'h4, 4'hB, 4'hD, 4'hE, 4'hA, 4'h5};
  logic [7:0] mask_tbl [8] = '{8'b01111001, 8'b10111100, 8'b11010110, 8'b11100011,
                               8'b01111110, 8'b10110111, 8'b11011011, 8'b11101101};

  function automatic logic [31:0] ref_rotl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] ref_g(logic [31:0] x);
    logic [3:0]  sw [8];
    logic [31:0] y = '0;
    for (int i = 0; i < 8; i++) sw[i] = sub_tbl[x[4*i +: 4]];
    for (int j = 0; j < 8; j++)
      for (int i = 0; i < 8; i++)
        if (mask_tbl[j][7-i]) y[4*j +: 4] = y[4*j +: 4] ^ sw[i];
    return y;
  endfunction

  function automatic logic [127:0] ref_perm(logic [127:0] s);
    logic [31:0] a, b, c, d, t, na, nb, nc, nd;
    int amt;
    a = s[31:0]; b = s[63:32]; c = s[95:64]; d = s[127:96];
    for (int r = 0; r < 48; r++) begin
      t   = d ^ 32'(r);
      amt = (r % 3 == 0) ? 19 : ((r % 3 == 1) ? 1 : 14);
      na  = t;
      nb  = ref_g(t ^ c) ^ a ^ b;
      nc  = b;
      nd  = ref_rotl(b, amt) ^ a ^ c;
      a = na; b = nb; c = nc; d = nd;
    end
    return {d, c, b, a};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [127:0] s, input bit poke);
    logic [127:0] exp;
    exp = ref_perm(s);
    @(negedge clk);
    start_i = 1'b1;
    state_i = s;
    @(negedge clk);
    start_i = 1'b0;
    state_i = ~s;
    check(busy1 && !done1, "R2 busy after start (x1)", 128'(busy1), 128'(1));
    check(busy4 && !done4, "R2 busy after start (x4)", 128'(busy4), 128'(1));
    for (int n = 2; n <= 49; n++) begin
      if (poke && n == 6) start_i = 1'b1;
      if (poke && n == 7) start_i = 1'b0;
      @(negedge clk);
      check(done1 == (n == 49), "R3 done timing x1", 128'(done1), 128'(n == 49));
      check(busy1 == (n < 49), "R3 busy timing x1 / R8", 128'(busy1), 128'(n < 49));
      check(done4 == (n == 13), "R10 done timing x4", 128'(done4), 128'(n == 13));
      if (n == 13) check(out4 == exp, "R10 x4 result R4 R5 R6 R7", out4, exp);
    end
    check(out1 == exp, "R4 R5 R6 R7 R8 result x1", out1, exp);
    @(negedge clk);
    check(!done1, "R3 done single pulse", 128'(done1), 128'(0));
    check(out1 == exp && out4 == exp, "R9 result held", out1, exp);
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy1 && !done1 && out1 == '0, "R1 reset state", out1, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy4 && !done4 && out4 == '0, "R1 after release", out4, '0);
    run_one('0, 1'b0);
    run_one('1, 1'b0);
    run_one(128'h0000_0001_0000_0000_0000_0000_8000_0000, 1'b0);
    run_one({$urandom, $urandom, $urandom, $urandom}, 1'b1);
    run_one({$urandom, $urandom, $urandom, $urandom}, 1'b0);
    run_one({$urandom, $urandom, $urandom, $urandom}, 1'b1);
    repeat (4) @(negedge clk);
    check(!busy1 && !done1, "R9 idle stays idle", 128'(busy1), 128'(0));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule